// File: doc/BRIEF.md
# Masked SIMD Variable Arithmetic Right Shifter

This block is a single-cycle registered vector datapath. It shifts every element of a packed source vector right arithmetically, and each element uses its own count, taken from the matching element of a second vector. Elements can be 16, 32 or 64 bits wide. The active vector length can be 128, 256 or 512 bits, and the register is always 512 bits wide.

A per-lane write mask chooses which lanes take the shifted result. A lane that is disabled either keeps the old destination value (merge) or is cleared (zero). Masking can also be switched off so that every active lane is written. In broadcast mode the count of the lowest lane is applied to every lane. A count that reaches or exceeds the element width saturates the lane to copies of its sign bit. Every bit above the active vector length is cleared.

The block sits behind an operand fetch stage. It takes both sources, the old destination value, the mask and the mode controls in one cycle, and it presents the new destination on the next rising clock edge.

Top module: `srav_unit`

## Requirements
- R1: Each active, written lane of `dout_o` equals the matching lane of `src1_i` shifted right arithmetically, one cycle after the inputs are applied. The vacated high bits take the lane's top bit. A count of zero returns the lane unchanged.
- R2: `esize_i` selects the element width: 0 gives 16 bits, 1 gives 32 bits, 2 gives 64 bits. The value 3 is treated as 64 bits. Lane j occupies bits [j*W+W-1 : j*W].
- R3: The count is the full unsigned value of the lane of `src2_i`. Any count of W or more sets every bit of the destination lane to the sign bit of the source lane.
- R4: `vlen_i` selects the active length: 0 gives 128 bits, 1 gives 256 bits, 2 gives 512 bits. The value 3 is treated as 512 bits. Every output bit at or above the active length is 0, whatever the mask or mode.
- R5: When `mask_en_i` is 1, bit j of `mask_i` enables lane j. When `mask_en_i` is 0, every active lane is written and `mask_i` has no effect.
- R6: With masking on and `zero_mode_i` at 0, a lane whose mask bit is 0 outputs the matching lane of `old_dst_i`.
- R7: With masking on and `zero_mode_i` at 1, a lane whose mask bit is 0 outputs 0.
- R8: When `bcast_i` is 1 and the element width is 32 or 64 bits, every lane uses the count in lane 0 of `src2_i`. With 16-bit elements, `bcast_i` is ignored.
- R9: While `rst_i` (synchronous, active high) is sampled at 1, `dout_o` is cleared to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| esize_i | input | 2 | Element width select |
| vlen_i | input | 2 | Active vector length select |
| mask_en_i | input | 1 | 1 applies the write mask |
| zero_mode_i | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| bcast_i | input | 1 | 1 applies the lane-0 count to all lanes |
| mask_i | input | 32 | Per-lane write mask, bit j for lane j |
| src1_i | input | 512 | Values to be shifted |
| src2_i | input | 512 | Per-lane shift counts |
| old_dst_i | input | 512 | Previous destination value used for merging |
| dout_o | output | 512 | Registered new destination |

## Verification
Several functions can act on one lane in the same cycle. A lane can saturate on an oversized count while its mask bit is 0, so the mask must win. Broadcast can also carry an oversized or zero count into lanes that sit above the active length, so the length clear must win. The bench provokes these overlaps by giving every lane a rotating pattern of counts (zero, W-1, W, a large value, a random legal value) with alternating signs. It then runs that pattern under random masks, for every width, length and mode combination. Each full vector is judged against a bit-level reference model that applies the shift first, then the mask or merge choice, then the length clear.

// File: rtl/srav_pkg.sv
package srav_pkg;
    localparam int MAX_VL  = 512;
    localparam int CHUNK_W = 16;
    localparam int NCHUNK  = MAX_VL / CHUNK_W;
    localparam int NMASK   = NCHUNK;
    localparam int CIW     = $clog2(NCHUNK);

    typedef enum logic [1:0] {ESZ_16 = 2'd0, ESZ_32 = 2'd1, ESZ_64 = 2'd2, ESZ_RSV = 2'd3} esz_e;
    typedef enum logic [1:0] {VL_128 = 2'd0, VL_256 = 2'd1, VL_512 = 2'd2, VL_RSV = 2'd3} vl_e;

    typedef struct packed {
        logic [MAX_VL-1:0] dout;
    } srav_state_t;
endpackage

// File: rtl/srav_lane.sv
module srav_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] res_o
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] WLIM = W'(W);

    always_comb begin
        if (cnt_i >= WLIM) begin
            res_o = {W{val_i[W-1]}};
        end else begin
            res_o = $signed(val_i) >>> cnt_i[SW-1:0];
        end
    end

    // R1 / R3: the top bit of the result always follows the source sign
    always_comb begin
        assert_sign_kept_R3: assert (res_o[W-1] == val_i[W-1]);
        if (cnt_i == '0) begin
            assert_zero_count_pass_R1: assert (res_o == val_i);
        end
    end
endmodule

// File: rtl/srav_lane_array.sv
module srav_lane_array #(
    parameter int EW = 32,
    parameter int VW = 512
) (
    input  logic [VW-1:0] src1_i,
    input  logic [VW-1:0] src2_i,
    input  logic          bcast_i,
    output logic [VW-1:0] res_o
);
    localparam int NL = VW / EW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [EW-1:0] cnt;
        assign cnt = bcast_i ? src2_i[EW-1:0] : src2_i[g*EW +: EW];
        srav_lane #(.W(EW)) lane_i (
            .val_i (src1_i[g*EW +: EW]),
            .cnt_i (cnt),
            .res_o (res_o[g*EW +: EW])
        );
    end
endmodule

// File: rtl/srav_wen_expand.sv
module srav_wen_expand
    import srav_pkg::*;
(
    input  esz_e              esize_i,
    input  vl_e               vlen_i,
    input  logic              mask_en_i,
    input  logic [NMASK-1:0]  mask_i,
    output logic [NCHUNK-1:0] chunk_act_o,
    output logic [NCHUNK-1:0] chunk_wr_o
);
    logic [CIW:0]   nact;
    logic [CIW-1:0] ci;
    logic [CIW-1:0] lane_idx;

    always_comb begin
        case (vlen_i)
            VL_128:  nact = (CIW+1)'(NCHUNK / 4);
            VL_256:  nact = (CIW+1)'(NCHUNK / 2);
            default: nact = (CIW+1)'(NCHUNK);
        endcase
        chunk_act_o = '0;
        chunk_wr_o  = '0;
        ci          = '0;
        lane_idx    = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            ci = CIW'(c);
            case (esize_i)
                ESZ_16:  lane_idx = ci;
                ESZ_32:  lane_idx = ci >> 1;
                default: lane_idx = ci >> 2;
            endcase
            chunk_act_o[c] = ({1'b0, ci} < nact);
            chunk_wr_o[c]  = chunk_act_o[c] && (!mask_en_i || mask_i[lane_idx]);
        end
    end
endmodule

// File: rtl/srav_unit.sv
module srav_unit
    import srav_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        esize_i,
    input  logic [1:0]        vlen_i,
    input  logic              mask_en_i,
    input  logic              zero_mode_i,
    input  logic              bcast_i,
    input  logic [NMASK-1:0]  mask_i,
    input  logic [MAX_VL-1:0] src1_i,
    input  logic [MAX_VL-1:0] src2_i,
    input  logic [MAX_VL-1:0] old_dst_i,
    output logic [MAX_VL-1:0] dout_o
);
    localparam int NWIDTH = 3;

    esz_e              esize;
    vl_e               vlen;
    logic              bcast_eff;
    logic [MAX_VL-1:0] res_all [NWIDTH];
    logic [MAX_VL-1:0] res_sel;
    logic [NCHUNK-1:0] chunk_act;
    logic [NCHUNK-1:0] chunk_wr;
    srav_state_t       st_d, st_q;

    assign esize     = esz_e'(esize_i);
    assign vlen      = vl_e'(vlen_i);
    assign bcast_eff = bcast_i && (esize != ESZ_16);

    for (genvar k = 0; k < NWIDTH; k++) begin : g_width
        logic bc;
        if (k == 0) begin : g_nobc
            assign bc = 1'b0;
        end else begin : g_bc
            assign bc = bcast_eff;
        end
        srav_lane_array #(.EW(CHUNK_W << k), .VW(MAX_VL)) arr_i (
            .src1_i  (src1_i),
            .src2_i  (src2_i),
            .bcast_i (bc),
            .res_o   (res_all[k])
        );
    end

    srav_wen_expand wen_i (
        .esize_i     (esize),
        .vlen_i      (vlen),
        .mask_en_i   (mask_en_i),
        .mask_i      (mask_i),
        .chunk_act_o (chunk_act),
        .chunk_wr_o  (chunk_wr)
    );

    always_comb begin
        case (esize)
            ESZ_16:  res_sel = res_all[0];
            ESZ_32:  res_sel = res_all[1];
            default: res_sel = res_all[2];
        endcase
        st_d = st_q;
        for (int c = 0; c < NCHUNK; c++) begin
            if (!chunk_act[c]) begin
                st_d.dout[c*CHUNK_W +: CHUNK_W] = '0;
            end else if (chunk_wr[c]) begin
                st_d.dout[c*CHUNK_W +: CHUNK_W] = res_sel[c*CHUNK_W +: CHUNK_W];
            end else if (zero_mode_i) begin
                st_d.dout[c*CHUNK_W +: CHUNK_W] = '0;
            end else begin
                st_d.dout[c*CHUNK_W +: CHUNK_W] = old_dst_i[c*CHUNK_W +: CHUNK_W];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.dout;

    // R4: nothing above a 128-bit active length survives
    assert_hi_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (vlen_i == 2'd0) |=> (dout_o[MAX_VL-1:MAX_VL/4] == '0));

    // R7: zeroing with an empty mask clears the whole result
    assert_zero_mode_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_en_i && zero_mode_i && mask_i == '0) |=> (dout_o == '0));

    // R6: merging with an empty mask at full length returns the old value
    assert_merge_keep_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_en_i && !zero_mode_i && mask_i == '0 && vlen_i[1]) |=> (dout_o == $past(old_dst_i)));

    // R5: with masking off the mask cannot zero a full-length result of unshifted data
    assert_nomask_write_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mask_en_i && vlen_i[1] && src2_i == '0 && !bcast_i) |=> (dout_o == $past(src1_i)));

    // R9: reset clears the output
    assert_reset_clear_R9: assert property (@(posedge clk_i)
        rst_i |=> (dout_o == '0));
endmodule

// File: tb/srav_unit_tb.sv
module srav_unit_tb_top;
    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst_i;
    logic [1:0]    esize_i, vlen_i;
    logic          mask_en_i, zero_mode_i, bcast_i;
    logic [31:0]   mask_i;
    logic [VW-1:0] src1_i, src2_i, old_dst_i;
    logic [VW-1:0] dout_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [VW-1:0] exp_q [$];
    string         tag_q [$];

    always #5 clk = ~clk;

    srav_unit dut_i (
        .clk_i(clk), .rst_i(rst_i), .esize_i(esize_i), .vlen_i(vlen_i),
        .mask_en_i(mask_en_i), .zero_mode_i(zero_mode_i), .bcast_i(bcast_i),
        .mask_i(mask_i), .src1_i(src1_i), .src2_i(src2_i), .old_dst_i(old_dst_i),
        .dout_o(dout_o)
    );

    function automatic int width_of(int es);
        return (es == 0) ? 16 : (es == 1) ? 32 : 64;
    endfunction

    function automatic logic [VW-1:0] ref_model(int es, int vl, bit men, bit zm, bit bc,
            logic [31:0] m, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] old);
        int w = width_of(es);
        int vlb = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
        bit ubc = bc && (w != 16);
        logic [63:0] c0 = '0;
        logic [VW-1:0] r = '0;
        for (int k = 0; k < w; k++) c0[k] = b[k];
        for (int j = 0; j < vlb / w; j++) begin
            logic [63:0] e = '0;
            logic [63:0] c = '0;
            logic sgn;
            for (int k = 0; k < w; k++) begin
                e[k] = a[j*w+k];
                c[k] = b[j*w+k];
            end
            if (ubc) c = c0;
            sgn = e[w-1];
            for (int k = 0; k < w; k++) begin
                if (!men || m[j]) begin
                    if (c >= 64'(w)) r[j*w+k] = sgn;
                    else if (64'(k) + c < 64'(w)) r[j*w+k] = e[64'(k) + c];
                    else r[j*w+k] = sgn;
                end else begin
                    r[j*w+k] = zm ? 1'b0 : old[j*w+k];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] signed_src(int w);
        logic [VW-1:0] v = rand_vec();
        for (int j = 0; j < VW / w; j++) v[j*w + w - 1] = j[0];
        return v;
    endfunction

    function automatic logic [VW-1:0] make_counts(int w, int off);
        logic [VW-1:0] v = '0;
        for (int j = 0; j < VW / w; j++) begin
            logic [63:0] c;
            case ((j + off) % 5)
                0: c = 64'd0;
                1: c = 64'(w - 1);
                2: c = 64'(w);
                3: c = 64'd1 << (w - 8);
                default: c = 64'($urandom_range(0, w - 1));
            endcase
            for (int k = 0; k < w; k++) v[j*w+k] = c[k];
        end
        return v;
    endfunction

    task automatic drive(int es, int vl, bit men, bit zm, bit bc, logic [31:0] m,
            logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] old, string tag);
        @(negedge clk);
        esize_i = 2'(es); vlen_i = 2'(vl); mask_en_i = men; zero_mode_i = zm;
        bcast_i = bc; mask_i = m; src1_i = a; src2_i = b; old_dst_i = old;
        exp_q.push_back(ref_model(es, vl, men, zm, bc, m, a, b, old));
        tag_q.push_back(tag);
    endtask

    // monitor: one cycle after each drive the result is registered
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (dout_o !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, dout_o, e);
                end
            end
        end
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_i = 1'b1; esize_i = '0; vlen_i = 2'd2; mask_en_i = 1'b0; zero_mode_i = 1'b0;
        bcast_i = 1'b0; mask_i = '0; src1_i = '1; src2_i = '0; old_dst_i = '1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (dout_o !== '0) begin
            errors++;
            $display("FAIL R9 reset actual=%h expected=0", dout_o);
        end
        @(negedge clk);
        rst_i = 1'b0;

        // sweep all widths, lengths and modes with mixed counts and signs
        for (int es = 0; es < 3; es++) begin
            for (int vl = 0; vl < 3; vl++) begin
                for (int md = 0; md < 8; md++) begin
                    int w = width_of(es);
                    string t;
                    if (md[2]) t = "R8 R3 R2";
                    else if (md[0] && md[1]) t = "R7 R3 R4";
                    else if (md[0]) t = "R6 R1 R4";
                    else t = "R5 R1 R3";
                    drive(es, vl, md[0], md[1], md[2], $urandom,
                          signed_src(w), make_counts(w, md + vl), rand_vec(), t);
                end
            end
        end

        // R1: zero counts pass the source through
        drive(1, 2, 1'b0, 1'b0, 1'b0, '0, rand_vec(), '0, rand_vec(), "R1 zero count");
        // R3: count equal to width on negative and positive lanes
        drive(0, 2, 1'b0, 1'b0, 1'b0, '0, signed_src(16), {32{16'h0010}}, '0, "R3 count16");
        drive(2, 2, 1'b0, 1'b0, 1'b0, '0, signed_src(64), {8{64'hFFFF_0000_0000_0000}}, '0, "R3 huge64");
        // R2: reserved width code behaves as 64-bit
        drive(3, 2, 1'b1, 1'b0, 1'b0, 32'h5A, signed_src(64), make_counts(64, 1), rand_vec(), "R2 code3");
        // R4: reserved length code behaves as 512
        drive(1, 3, 1'b0, 1'b0, 1'b0, '0, signed_src(32), make_counts(32, 2), rand_vec(), "R4 code3");
        drive(0, 0, 1'b0, 1'b0, 1'b0, '0, rand_vec(), '0, rand_vec(), "R4 len128");
        // R5: mask ignored when masking off
        drive(0, 2, 1'b0, 1'b1, 1'b0, '0, signed_src(16), make_counts(16, 3), rand_vec(), "R5 mask off");
        // R6: merge with empty mask keeps old value
        drive(1, 2, 1'b1, 1'b0, 1'b0, '0, rand_vec(), rand_vec(), rand_vec(), "R6 empty mask");
        // R7: zeroing with alternating mask
        drive(2, 2, 1'b1, 1'b1, 1'b0, 32'hAA, signed_src(64), make_counts(64, 4), rand_vec(), "R7 alt mask");
        // R8: broadcast ignored for 16-bit, used for 32-bit with oversized count
        drive(0, 2, 1'b0, 1'b0, 1'b1, '0, signed_src(16), make_counts(16, 0), '0, "R8 bc16 ignored");
        drive(1, 1, 1'b1, 1'b0, 1'b1, 32'h3C, signed_src(32), make_counts(32, 3), rand_vec(), "R8 bc32 big");
        drive(2, 2, 1'b0, 1'b0, 1'b1, '0, signed_src(64), make_counts(64, 1), '0, "R8 bc64 w-1");

        repeat (4) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R9 pending actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule